// File: doc/BRIEF.md
# Width-Aware Receive Lane Reversal Mapper

This block sits between the four physical receive lanes of one link port and the port's logical lanes. On every clock it copies each logical lane's symbol and valid bit from a physical lane. Which physical lane that is depends on the configured maximum link width (x4, x2 or x1) and on whether the lanes are reversed. The copy is registered, so there is one cycle of latency.

Whether the lanes are reversed is decided automatically while training is in progress. A small detector compares the lane-number fields of training sets arriving on physical lane 0 and on the highest physical lane in use. It latches the result and holds it until training restarts or the link goes down. The training state machine that drives the training and link indications is outside this block.

Top module: `lane_rev_mapper`

## Requirements
- R1: After reset, all logical data outputs are zero, all logical valid outputs are 0 and `reversed_o` is 0.
- R2: With the width field equal to 4'h4 and no reversal, logical lane l carries physical lane l's data and valid one clock after they are presented.
- R3: With width 4'h4 and reversal, logical lane l carries physical lane 3-l's data and valid one clock later.
- R4: With width 4'h2, logical lanes 0 and 1 come from physical lanes 0 and 1, swapped when reversed. Logical lanes 2 and 3 output zero data with valid 0.
- R5: With width 4'h1, logical lane 0 always comes from physical lane 0, `reversed_o` is 0, and logical lanes 1 to 3 output zero data with valid 0.
- R6: While training is active, the detector looks at the training sets seen in a single cycle. If physical lane 0 reports lane number width-1 and physical lane width-1 reports lane number 0, `reversed_o` becomes 1 after the next clock edge. The opposite pattern (lane 0 reports 0, the top lane reports width-1) sets it back to 0.
- R7: While training is inactive and the link is up, training-set indications do not change the reversal decision.
- R8: The reversal decision clears to 0 when the link-up input is low, and in the cycle that training restarts (the training input rises).
- R9: A width field value other than 4'h1, 4'h2 or 4'h4 is treated as x1, and `reversed_o` is then 0 even if a reversal was latched earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| max_width_i | input | 4 | Maximum link width field (4'h4, 4'h2, 4'h1) |
| link_up_i | input | 1 | Link up; low clears the reversal decision |
| train_active_i | input | 1 | Training in progress; enables detection |
| phy_data_i | input | LANES*DATA_W | Physical lane symbols, lane p at [p*DATA_W +: DATA_W] |
| phy_valid_i | input | LANES | Physical lane symbol valid |
| ts_seen_i | input | LANES | A training set's lane number is present on that lane this cycle |
| ts_lane_num_i | input | LANES*LNUM_W | Received training-set lane number for each physical lane |
| log_data_o | output | LANES*DATA_W | Logical lane symbols, registered |
| log_valid_o | output | LANES | Logical lane valid, registered |
| reversed_o | output | 1 | Lanes are currently mapped reversed |

## Verification
If the latched decision is wrong, `reversed_o` shows it one cycle after the deciding training set. The data on every logical lane is permuted from the following cycle on. A wrong source index or a wrong width decode shows up as misplaced or leaking symbols, and as valid bits outside the configured width, on the first registered cycle after the input. Distinct per-lane symbol values and asymmetric valid patterns make every permutation error visible within one cycle.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
  localparam int unsigned MW_FIELD_W = 4;

  // Decode width field; unsupported or oversized codes fall back to x1
  function automatic int unsigned eff_width(logic [MW_FIELD_W-1:0] code, int unsigned lanes);
    case (code)
      4'h4:    return (lanes >= 4) ? 4 : 1;
      4'h2:    return (lanes >= 2) ? 2 : 1;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/lrm_detect.sv
module lrm_detect #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LNUM_W = 8,
  localparam int unsigned WW    = $clog2(LANES) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [WW-1:0]           width_i,
  input  logic                    link_up_i,
  input  logic                    train_i,
  input  logic [LANES-1:0]        ts_seen_i,
  input  logic [LANES*LNUM_W-1:0] ts_lnum_i,
  output logic                    rev_o
);
  logic train_q, rev_q;
  logic rev_pat, nrm_pat;
  int   top;

  always_comb begin
    top = int'(width_i) - 1;
    if (top < 0) top = 0;
    rev_pat = (width_i > WW'(1)) && ts_seen_i[0] && ts_seen_i[top] &&
              (ts_lnum_i[0 +: LNUM_W] == LNUM_W'(top)) &&
              (ts_lnum_i[top*LNUM_W +: LNUM_W] == '0);
    nrm_pat = (width_i > WW'(1)) && ts_seen_i[0] && ts_seen_i[top] &&
              (ts_lnum_i[0 +: LNUM_W] == '0) &&
              (ts_lnum_i[top*LNUM_W +: LNUM_W] == LNUM_W'(top));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      train_q <= 1'b0;
      rev_q   <= 1'b0;
    end else begin
      train_q <= train_i;
      if (!link_up_i)                rev_q <= 1'b0;
      else if (train_i && !train_q)  rev_q <= 1'b0;  // restart
      else if (train_i && rev_pat)   rev_q <= 1'b1;
      else if (train_i && nrm_pat)   rev_q <= 1'b0;
    end
  end

  assign rev_o = rev_q;
endmodule

// File: rtl/lrm_xbar.sv
module lrm_xbar #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned WW    = $clog2(LANES) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [WW-1:0]           width_i,
  input  logic                    rev_i,
  input  logic [LANES*DATA_W-1:0] phy_data_i,
  input  logic [LANES-1:0]        phy_valid_i,
  output logic [LANES*DATA_W-1:0] log_data_o,
  output logic [LANES-1:0]        log_valid_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              act;
    int                src;
    logic [DATA_W-1:0] d_q;
    logic              v_q;

    always_comb begin
      act = (l < int'(width_i));
      src = 0;
      if (act) src = rev_i ? (int'(width_i) - 1 - l) : l;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (act) begin
        d_q <= phy_data_i[src*DATA_W +: DATA_W];
        v_q <= phy_valid_i[src];
      end else begin
        d_q <= '0;
        v_q <= 1'b0;
      end
    end

    assign log_data_o[l*DATA_W +: DATA_W] = d_q;
    assign log_valid_o[l]                 = v_q;
  end
endmodule

// File: rtl/lane_rev_mapper.sv
module lane_rev_mapper #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LNUM_W = 8,
  localparam int unsigned WW    = $clog2(LANES) + 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [lrm_pkg::MW_FIELD_W-1:0]      max_width_i,
  input  logic                                link_up_i,
  input  logic                                train_active_i,
  input  logic [LANES*DATA_W-1:0]             phy_data_i,
  input  logic [LANES-1:0]                    phy_valid_i,
  input  logic [LANES-1:0]                    ts_seen_i,
  input  logic [LANES*LNUM_W-1:0]             ts_lane_num_i,
  output logic [LANES*DATA_W-1:0]             log_data_o,
  output logic [LANES-1:0]                    log_valid_o,
  output logic                                reversed_o
);
  logic [WW-1:0] eff_w;
  logic          rev_raw;
  logic          wide;

  assign eff_w = WW'(lrm_pkg::eff_width(max_width_i, LANES));
  assign wide  = (eff_w > WW'(1));
  assign reversed_o = rev_raw & wide;

  lrm_detect #(.LANES(LANES), .LNUM_W(LNUM_W)) detect_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .width_i   (eff_w),
    .link_up_i (link_up_i),
    .train_i   (train_active_i),
    .ts_seen_i (ts_seen_i),
    .ts_lnum_i (ts_lane_num_i),
    .rev_o     (rev_raw)
  );

  lrm_xbar #(.LANES(LANES), .DATA_W(DATA_W)) xbar_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .width_i     (eff_w),
    .rev_i       (reversed_o),
    .phy_data_i  (phy_data_i),
    .phy_valid_i (phy_valid_i),
    .log_data_o  (log_data_o),
    .log_valid_o (log_valid_o)
  );
endmodule

// File: rtl/lrm_chk.sv
module lrm_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [3:0]              max_width_i,
  input logic                    link_up_i,
  input logic                    train_active_i,
  input logic [LANES-1:0]        phy_valid_i,
  input logic [LANES*DATA_W-1:0] log_data_o,
  input logic [LANES-1:0]        log_valid_o,
  input logic                    reversed_o,
  input logic                    rev_raw
);
  AST_X4_VALID_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_width_i == 4'h4) |=> ($countones(log_valid_o) == $countones($past(phy_valid_i)))); // R2

  AST_X2_UPPER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_width_i == 4'h2) |=> (log_valid_o[LANES-1:2] == '0 && log_data_o[LANES*DATA_W-1:2*DATA_W] == '0)); // R4

  AST_X1_UPPER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_width_i == 4'h1) |=> (log_valid_o[LANES-1:1] == '0)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_up_i && !train_active_i) |=> $stable(rev_raw)); // R7

  AST_LINK_DOWN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_up_i) |=> !rev_raw); // R8

  AST_BAD_WIDTH_NO_REV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(max_width_i inside {4'h2, 4'h4}) |-> !reversed_o); // R9
endmodule

bind lane_rev_mapper lrm_chk #(.LANES(LANES), .DATA_W(DATA_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .max_width_i    (max_width_i),
  .link_up_i      (link_up_i),
  .train_active_i (train_active_i),
  .phy_valid_i    (phy_valid_i),
  .log_data_o     (log_data_o),
  .log_valid_o    (log_valid_o),
  .reversed_o     (reversed_o),
  .rev_raw        (rev_raw)
);

// File: tb/lane_rev_mapper_tb.sv
module lane_rev_mapper_tb_top;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LNUM_W = 8;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [3:0]              max_width_i = 4'h4;
  logic                    link_up_i = 1'b0;
  logic                    train_active_i = 1'b0;
  logic [LANES*DATA_W-1:0] phy_data_i = '0;
  logic [LANES-1:0]        phy_valid_i = '0;
  logic [LANES-1:0]        ts_seen_i = '0;
  logic [LANES*LNUM_W-1:0] ts_lane_num_i = '0;
  logic [LANES*DATA_W-1:0] log_data_o;
  logic [LANES-1:0]        log_valid_o;
  logic                    reversed_o;

  int n_chk = 0;
  int n_err = 0;

  always #4ns clk_i = ~clk_i;

  lane_rev_mapper #(.LANES(LANES), .DATA_W(DATA_W), .LNUM_W(LNUM_W)) dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // Drive a training-set pattern for one cycle: lane p reports lnum[p]
  task automatic send_ts(logic [LANES-1:0] seen, int l0, int l1, int l2, int l3);
    ts_seen_i = seen;
    ts_lane_num_i = {LNUM_W'(l3), LNUM_W'(l2), LNUM_W'(l1), LNUM_W'(l0)};
    tick();
    ts_seen_i = '0;
  endtask

  // Present data, then compare outputs with the expected mapping
  task automatic send_check(string req, int w, bit rev, logic [LANES-1:0] vld);
    logic [LANES*DATA_W-1:0] exp_d;
    logic [LANES-1:0]        exp_v;
    for (int p = 0; p < LANES; p++) phy_data_i[p*DATA_W +: DATA_W] = DATA_W'(8'hA0 + p * 8'h11);
    phy_valid_i = vld;
    exp_d = '0;
    exp_v = '0;
    for (int l = 0; l < w; l++) begin
      int s;
      s = rev ? (w - 1 - l) : l;
      exp_d[l*DATA_W +: DATA_W] = phy_data_i[s*DATA_W +: DATA_W];
      exp_v[l] = vld[s];
    end
    tick();
    chk({req, " data"}, 64'(log_data_o), 64'(exp_d));
    chk({req, " valid"}, 64'(log_valid_o), 64'(exp_v));
    phy_valid_i = '0;
  endtask

  task automatic restart_training();
    train_active_i = 1'b0;
    tick();
    train_active_i = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 data", 64'(log_data_o), 64'h0);
    chk("R1 valid", 64'(log_valid_o), 64'h0);
    chk("R1 reversed", 64'(reversed_o), 64'h0);
  endtask

  task automatic t_x4_normal();
    max_width_i = 4'h4;
    link_up_i = 1'b1;
    restart_training();
    send_ts(4'b1111, 0, 1, 2, 3);
    chk("R6 normal pattern", 64'(reversed_o), 64'h0);
    send_check("R2 x4 identity", 4, 1'b0, 4'b1111);
    send_check("R2 x4 partial valid", 4, 1'b0, 4'b0101);
  endtask

  task automatic t_x4_rev();
    send_ts(4'b1001, 3, 0, 0, 0);
    chk("R6 reversal detected", 64'(reversed_o), 64'h1);
    send_check("R3 x4 reversed", 4, 1'b1, 4'b1111);
    send_check("R3 x4 reversed valid", 4, 1'b1, 4'b0011);
  endtask

  task automatic t_hold();
    train_active_i = 1'b0;
    tick();
    send_ts(4'b1001, 0, 1, 2, 3);
    chk("R7 held while idle", 64'(reversed_o), 64'h1);
    send_check("R7 mapping held", 4, 1'b1, 4'b1010);
  endtask

  task automatic t_x2();
    max_width_i = 4'h2;
    train_active_i = 1'b1;
    tick();
    chk("R8 restart clears", 64'(reversed_o), 64'h0);
    send_check("R4 x2 normal", 2, 1'b0, 4'b1101);
    send_ts(4'b0011, 1, 0, 0, 0);
    chk("R6 x2 reversal", 64'(reversed_o), 64'h1);
    send_check("R4 x2 swapped", 2, 1'b1, 4'b1101);
    send_ts(4'b0011, 0, 1, 0, 0);
    chk("R6 normal clears", 64'(reversed_o), 64'h0);
    send_ts(4'b0011, 1, 0, 0, 0);
  endtask

  task automatic t_link_down();
    link_up_i = 1'b0;
    tick();
    chk("R8 link down clears", 64'(reversed_o), 64'h0);
    link_up_i = 1'b1;
  endtask

  task automatic t_x1();
    max_width_i = 4'h1;
    restart_training();
    send_ts(4'b1111, 0, 0, 0, 0);
    chk("R5 x1 reversed", 64'(reversed_o), 64'h0);
    send_check("R5 x1 map", 1, 1'b0, 4'b1111);
  endtask

  task automatic t_bad_width();
    max_width_i = 4'h4;
    restart_training();
    send_ts(4'b1001, 3, 0, 0, 0);
    chk("R9 setup reversed", 64'(reversed_o), 64'h1);
    train_active_i = 1'b0;
    max_width_i = 4'h3;
    tick();
    chk("R9 bad width flag", 64'(reversed_o), 64'h0);
    send_check("R9 bad width as x1", 1, 1'b0, 4'b1111);
    max_width_i = 4'h4;
    tick();
    chk("R9 latch kept", 64'(reversed_o), 64'h1);
  endtask

  initial begin
    #100us;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_x4_normal();
    t_x4_rev();
    t_hold();
    t_x2();
    t_link_down();
    t_x1();
    t_bad_width();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule